// File: doc/BRIEF.md
# MIDI Running-Status Message Decoder

This block sits between a byte-level serial receiver and a control state machine. It accepts one byte at a time from the receiver's holding register, acknowledges each byte with a single-cycle pulse so the receiver can clear that register, and assembles the bytes into complete MIDI channel messages. A status byte (most significant bit set) is latched and starts a new message. Data bytes that arrive with no new status byte reuse the latched status, which is known as running status.

The decoder knows how many data bytes each channel message needs. It raises nothing until the final data byte has arrived. On completion it pulses exactly one bit of an event-flag vector for one cycle. It also loads the status byte and the data bytes into an output buffer. The buffer keeps that message until the next message completes, so the consumer can read it at its own pace. Bytes flagged with a receive error, real-time bytes and system-common bytes are each handled by a fixed rule, so a corrupted or interleaved stream cannot produce a wrong message.

Top module: `midi_rs_decoder`

## Requirements
- R1: A byte is taken on a rising edge where `rx_valid` is high and `rx_ack` is low. `rx_ack` is high for exactly the one cycle after that edge, so each byte held by the receiver is taken once.
- R2: A byte in 0x80–0xEF is latched as the running status. It discards any partly received message and raises no event.
- R3: After a message completes, further data bytes (0x00–0x7F) with no new status byte form a new message under the latched status.
- R4: Statuses with upper nibble 0xC (program change) or 0xD (channel pressure) complete after one data byte. Upper nibbles 0x8, 0x9, 0xA, 0xB and 0xE complete after two. No event is raised before the last data byte.
- R5: On completion `evt_flags` has exactly one bit set, for the single cycle in which `rx_ack` acknowledges the final data byte. The bits are: bit0 note-off (0x8), bit1 note-on (0x9), bit2 poly pressure (0xA), bit3 control change (0xB), bit4 program change (0xC), bit5 channel pressure (0xD), bit6 pitch bend (0xE). In all other cycles `evt_flags` is zero.
- R6: On completion `msg_status`, `msg_data1` and `msg_data2` take the status byte, the first data byte and the second data byte. `msg_data2` is 0x00 for a one-data-byte message. The three outputs hold their values until the next completion.
- R7: A note-on message (0x9n) whose second data byte is 0x00 sets bit0 (note-off) instead of bit1. `msg_status` still shows the received 0x9n.
- R8: A byte taken while `rx_err` is high is acknowledged but discarded. The data-byte count restarts from zero and the latched status is kept.
- R9: Bytes 0xF8–0xFF are acknowledged and otherwise ignored. They leave the latched status and any partly received message unchanged.
- R10: Bytes 0xF0–0xF7 cancel running status. Data bytes that follow are ignored until the next byte in 0x80–0xEF.
- R11: Data bytes taken when no status is latched are ignored. This covers the bytes that arrive after reset.
- R12: While `rst` is high and after it is released, `rx_ack` and `evt_flags` are zero and the three message outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte in the receiver's holding register |
| rx_valid | input | 1 | Holding register contains an unread byte |
| rx_err | input | 1 | The held byte was received with an error |
| rx_ack | output | 1 | One-cycle pulse: byte taken, receiver may clear |
| evt_flags | output | 7 | One-hot message-complete event, one cycle |
| msg_status | output | 8 | Status byte of the last completed message |
| msg_data1 | output | 8 | First data byte of the last completed message |
| msg_data2 | output | 8 | Second data byte, 0x00 for one-byte messages |

## Verification
The bench targets the places where a decoder can mis-count data bytes. One is a run of data bytes under running status; a decoder that clears its status after each message would go silent there. Another is a one-data-byte status; a decoder that waits for two bytes would shift the pairing of every later message. The bench also sends a new status in the middle of a message, an errored byte between two data bytes, and a real-time byte inside a message. A decoder that gets these wrong would report stale first data bytes, would lose the status, or would finish messages early. The velocity-zero note-on case, a system-common byte that cancels running status, and stray data bytes after reset check that no wrong flag and no phantom event appear.

// File: rtl/midi_rs_pkg.sv
package midi_rs_pkg;

    localparam int BYTE_W = 8;
    localparam int EVT_N  = 7;
    localparam int EVT_IW = $clog2(EVT_N);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        BK_DATA,     // 0x00-0x7F
        BK_CHAN,     // 0x80-0xEF
        BK_SYSCOM,   // 0xF0-0xF7
        BK_RT        // 0xF8-0xFF
    } byte_kind_e;

    typedef enum logic [EVT_IW-1:0] {
        EV_NOTE_OFF = 3'd0,
        EV_NOTE_ON  = 3'd1,
        EV_POLY     = 3'd2,
        EV_CTRL     = 3'd3,
        EV_PROG     = 3'd4,
        EV_CHPRESS  = 3'd5,
        EV_BEND     = 3'd6
    } evt_e;

    typedef struct packed {
        byte_t status;
        byte_t d1;
        byte_t d2;
    } msg_t;

    function automatic byte_kind_e classify_byte(input byte_t b);
        if (!b[BYTE_W-1])               return BK_DATA;
        else if (b[BYTE_W-2:BYTE_W-4] != 3'b111) return BK_CHAN;
        else if (!b[BYTE_W-5])          return BK_SYSCOM;
        else                            return BK_RT;
    endfunction

    // Program change and channel pressure carry one data byte
    function automatic logic single_data(input byte_t s);
        return (s[BYTE_W-1:BYTE_W-4] == 4'hC) || (s[BYTE_W-1:BYTE_W-4] == 4'hD);
    endfunction

    function automatic evt_e plain_event(input byte_t s);
        case (s[BYTE_W-2:BYTE_W-4])
            3'd0:    return EV_NOTE_OFF;
            3'd1:    return EV_NOTE_ON;
            3'd2:    return EV_POLY;
            3'd3:    return EV_CTRL;
            3'd4:    return EV_PROG;
            3'd5:    return EV_CHPRESS;
            default: return EV_BEND;
        endcase
    endfunction

endpackage

// File: rtl/midi_rs_rx_if.sv
module midi_rs_rx_if (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    output logic take,
    output logic rx_ack
);
    logic ack_q;

    assign take   = rx_valid & ~ack_q;
    assign rx_ack = ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= take;
    end
endmodule

// File: rtl/midi_rs_classify.sv
module midi_rs_classify
    import midi_rs_pkg::*;
(
    input  byte_t      in_byte,
    output byte_kind_e kind
);
    always_comb kind = classify_byte(in_byte);
endmodule

// File: rtl/midi_rs_assembler.sv
module midi_rs_assembler
    import midi_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       err,
    input  byte_t      in_byte,
    input  byte_kind_e kind,
    output logic       done,
    output msg_t       msg
);
    byte_t run_status;
    logic  run_ok;
    logic  have_d1;
    byte_t d1_q;
    logic  data_ok;

    assign data_ok = take & ~err & (kind == BK_DATA) & run_ok;

    always_comb begin
        done       = 1'b0;
        msg.status = run_status;
        msg.d1     = in_byte;
        msg.d2     = '0;
        if (data_ok) begin
            if (have_d1) begin
                done   = 1'b1;
                msg.d1 = d1_q;
                msg.d2 = in_byte;
            end else if (single_data(run_status)) begin
                done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_status <= '0;
            run_ok     <= 1'b0;
            have_d1    <= 1'b0;
            d1_q       <= '0;
        end else if (take) begin
            if (err) begin
                have_d1 <= 1'b0;
            end else begin
                case (kind)
                    BK_CHAN: begin
                        run_status <= in_byte;
                        run_ok     <= 1'b1;
                        have_d1    <= 1'b0;
                    end
                    BK_SYSCOM: begin
                        run_ok  <= 1'b0;
                        have_d1 <= 1'b0;
                    end
                    BK_DATA: begin
                        if (run_ok) begin
                            if (have_d1 || single_data(run_status)) begin
                                have_d1 <= 1'b0;
                            end else begin
                                have_d1 <= 1'b1;
                                d1_q    <= in_byte;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/midi_rs_event.sv
module midi_rs_event
    import midi_rs_pkg::*;
#(
    parameter int EVT_W        = EVT_N,
    parameter bit ZERO_VEL_OFF = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  msg_t             msg,
    output logic [EVT_W-1:0] evt_flags,
    output msg_t             held
);
    evt_e kind_sel;

    generate
        if (ZERO_VEL_OFF) begin : g_vel0
            always_comb begin
                kind_sel = plain_event(msg.status);
                if (kind_sel == EV_NOTE_ON && msg.d2 == '0)
                    kind_sel = EV_NOTE_OFF;
            end
        end else begin : g_plain
            always_comb kind_sel = plain_event(msg.status);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_flags <= '0;
            held      <= '0;
        end else begin
            evt_flags <= '0;
            if (done) begin
                evt_flags <= EVT_W'(1) << kind_sel;
                held      <= msg;
            end
        end
    end
endmodule

// File: rtl/midi_rs_decoder.sv
module midi_rs_decoder
    import midi_rs_pkg::*;
#(
    parameter bit ZERO_VEL_OFF = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  rx_valid,
    input  logic                  rx_err,
    output logic                  rx_ack,
    output logic [EVT_N-1:0]      evt_flags,
    output logic [BYTE_W-1:0]     msg_status,
    output logic [BYTE_W-1:0]     msg_data1,
    output logic [BYTE_W-1:0]     msg_data2
);
    logic       take;
    byte_kind_e kind;
    logic       done;
    msg_t       asm_msg;
    msg_t       held;

    midi_rs_rx_if u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .take     (take),
        .rx_ack   (rx_ack)
    );

    midi_rs_classify u_cls (
        .in_byte (rx_byte),
        .kind    (kind)
    );

    midi_rs_assembler u_asm (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .err     (rx_err),
        .in_byte (rx_byte),
        .kind    (kind),
        .done    (done),
        .msg     (asm_msg)
    );

    midi_rs_event #(
        .EVT_W        (EVT_N),
        .ZERO_VEL_OFF (ZERO_VEL_OFF)
    ) u_evt (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .msg       (asm_msg),
        .evt_flags (evt_flags),
        .held      (held)
    );

    assign msg_status = held.status;
    assign msg_data1  = held.d1;
    assign msg_data2  = held.d2;
endmodule

// File: rtl/midi_rs_decoder_chk.sv
module midi_rs_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_err,
    input logic       rx_ack,
    input logic [6:0] evt_flags,
    input logic [7:0] msg_status,
    input logic [7:0] msg_data1,
    input logic [7:0] msg_data2
);
    // R1: acknowledge lasts a single cycle
    a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
        rx_ack |=> !rx_ack);

    // R1: a held byte is acknowledged on the next cycle
    a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack) |=> rx_ack);

    // R5: never more than one flag
    a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_flags));

    // R5: an event coincides with the acknowledge of its final byte
    a_r5_with_ack: assert property (@(posedge clk) disable iff (rst)
        (evt_flags != 7'd0) |-> rx_ack);

    // R6: buffer changes only with an event
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (evt_flags == 7'd0 && !$past(rst)) |->
            ($stable(msg_status) && $stable(msg_data1) && $stable(msg_data2)));

    // R6: a reported message always carries a status byte
    a_r6_status_msb: assert property (@(posedge clk) disable iff (rst)
        (evt_flags != 7'd0) |-> msg_status[7]);

    // R8: an errored byte never completes a message
    a_r8_err_silent: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack && rx_err) |=> (evt_flags == 7'd0));

    // R9: a real-time byte never completes a message
    a_r9_rt_silent: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack && rx_byte[7:3] == 5'b11111) |=> (evt_flags == 7'd0));

    // R2: a status byte never completes a message
    a_r2_status_silent: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack && rx_byte[7]) |=> (evt_flags == 7'd0));
endmodule

bind midi_rs_decoder midi_rs_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_err     (rx_err),
    .rx_ack     (rx_ack),
    .evt_flags  (evt_flags),
    .msg_status (msg_status),
    .msg_data1  (msg_data1),
    .msg_data2  (msg_data2)
);

// File: tb/midi_rs_decoder_test.sv
module midi_rs_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_err = 1'b0;
    logic       rx_ack;
    logic [6:0] evt_flags;
    logic [7:0] msg_status, msg_data1, msg_data2;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    midi_rs_decoder uut (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_err     (rx_err),
        .rx_ack     (rx_ack),
        .evt_flags  (evt_flags),
        .msg_status (msg_status),
        .msg_data1  (msg_data1),
        .msg_data2  (msg_data2)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Hand one byte over the holding-register handshake; return the flags seen with the acknowledge
    task automatic send(input logic [7:0] b, input logic e, output logic [6:0] ev);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        rx_err   = e;
        @(negedge clk);
        check("R1 ack after take", {31'd0, rx_ack}, 32'd1);
        ev = evt_flags;
        rx_valid = 1'b0;
        rx_err   = 1'b0;
        @(negedge clk);
        check("R1/R5 single-cycle pulse", {24'd0, rx_ack, evt_flags}, 32'd0);
    endtask

    task automatic check_buf(input string req, input logic [7:0] s, input logic [7:0] a, input logic [7:0] b);
        check(req, {8'd0, msg_status, msg_data1, msg_data2}, {8'd0, s, a, b});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 reset ack/flags", {24'd0, rx_ack, evt_flags}, 32'd0);
        check_buf("R12 reset buffer", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_orphan_data();
        logic [6:0] ev;
        do_reset();
        send(8'h10, 1'b0, ev); check("R11 orphan data 1", {25'd0, ev}, 32'd0);
        send(8'h20, 1'b0, ev); check("R11 orphan data 2", {25'd0, ev}, 32'd0);
        check_buf("R11 buffer untouched", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_note_on();
        logic [6:0] ev;
        send(8'h93, 1'b0, ev); check("R2 status no event", {25'd0, ev}, 32'd0);
        send(8'h40, 1'b0, ev); check("R4 wait for second byte", {25'd0, ev}, 32'd0);
        check_buf("R6 buffer held before completion", 8'h00, 8'h00, 8'h00);
        send(8'h64, 1'b0, ev); check("R5 note-on flag bit1", {25'd0, ev}, 32'h02);
        check_buf("R6 note-on buffer", 8'h93, 8'h40, 8'h64);
    endtask

    task automatic t_running();
        logic [6:0] ev;
        send(8'h41, 1'b0, ev); check("R4 running first byte", {25'd0, ev}, 32'd0);
        check_buf("R6 buffer held between", 8'h93, 8'h40, 8'h64);
        send(8'h50, 1'b0, ev); check("R3 running status event", {25'd0, ev}, 32'h02);
        check_buf("R3 running buffer", 8'h93, 8'h41, 8'h50);
    endtask

    task automatic t_vel_zero();
        logic [6:0] ev;
        send(8'h41, 1'b0, ev);
        send(8'h00, 1'b0, ev); check("R7 velocity zero is note-off", {25'd0, ev}, 32'h01);
        check_buf("R7 status kept as note-on", 8'h93, 8'h41, 8'h00);
    endtask

    task automatic t_one_byte();
        logic [6:0] ev;
        send(8'hC5, 1'b0, ev);
        send(8'h07, 1'b0, ev); check("R4 program change one byte", {25'd0, ev}, 32'h10);
        check_buf("R6 one-byte buffer", 8'hC5, 8'h07, 8'h00);
        send(8'h08, 1'b0, ev); check("R3 running program change", {25'd0, ev}, 32'h10);
        check_buf("R3 running one-byte buffer", 8'hC5, 8'h08, 8'h00);
        send(8'hD2, 1'b0, ev);
        send(8'h33, 1'b0, ev); check("R4 channel pressure one byte", {25'd0, ev}, 32'h20);
        check_buf("R6 pressure buffer", 8'hD2, 8'h33, 8'h00);
    endtask

    task automatic t_other_kinds();
        logic [6:0] ev;
        send(8'hE0, 1'b0, ev);
        send(8'h01, 1'b0, ev); check("R4 bend waits", {25'd0, ev}, 32'd0);
        send(8'h02, 1'b0, ev); check("R5 pitch bend bit6", {25'd0, ev}, 32'h40);
        send(8'hA4, 1'b0, ev);
        send(8'h3C, 1'b0, ev);
        send(8'h11, 1'b0, ev); check("R5 poly pressure bit2", {25'd0, ev}, 32'h04);
        send(8'h82, 1'b0, ev);
        send(8'h3C, 1'b0, ev);
        send(8'h40, 1'b0, ev); check("R5 note-off bit0", {25'd0, ev}, 32'h01);
        check_buf("R6 note-off buffer", 8'h82, 8'h3C, 8'h40);
    endtask

    task automatic t_status_mid();
        logic [6:0] ev;
        send(8'h90, 1'b0, ev);
        send(8'h10, 1'b0, ev);
        send(8'hB2, 1'b0, ev); check("R2 new status mid-message", {25'd0, ev}, 32'd0);
        send(8'h07, 1'b0, ev); check("R2 partial discarded", {25'd0, ev}, 32'd0);
        send(8'h7F, 1'b0, ev); check("R5 control change bit3", {25'd0, ev}, 32'h08);
        check_buf("R2 buffer after restart", 8'hB2, 8'h07, 8'h7F);
    endtask

    task automatic t_error();
        logic [6:0] ev;
        send(8'h90, 1'b0, ev);
        send(8'h3C, 1'b0, ev);
        send(8'h55, 1'b1, ev); check("R8 errored byte dropped", {25'd0, ev}, 32'd0);
        send(8'h3D, 1'b0, ev); check("R8 count restarted", {25'd0, ev}, 32'd0);
        send(8'h40, 1'b0, ev); check("R8 status kept", {25'd0, ev}, 32'h02);
        check_buf("R8 buffer", 8'h90, 8'h3D, 8'h40);
        send(8'hC1, 1'b1, ev); check("R8 errored status dropped", {25'd0, ev}, 32'd0);
        send(8'h11, 1'b0, ev);
        send(8'h22, 1'b0, ev); check("R8 errored status not latched", {25'd0, ev}, 32'h02);
        check_buf("R8 buffer status", 8'h90, 8'h11, 8'h22);
    endtask

    task automatic t_realtime();
        logic [6:0] ev;
        send(8'h90, 1'b0, ev);
        send(8'h3C, 1'b0, ev);
        send(8'hF8, 1'b0, ev); check("R9 clock byte ignored", {25'd0, ev}, 32'd0);
        send(8'hFE, 1'b0, ev); check("R9 sense byte ignored", {25'd0, ev}, 32'd0);
        check_buf("R9 buffer untouched", 8'h90, 8'h11, 8'h22);
        send(8'h40, 1'b0, ev); check("R9 partial message intact", {25'd0, ev}, 32'h02);
        check_buf("R9 buffer", 8'h90, 8'h3C, 8'h40);
    endtask

    task automatic t_syscom();
        logic [6:0] ev;
        send(8'hF2, 1'b0, ev); check("R10 system common no event", {25'd0, ev}, 32'd0);
        send(8'h10, 1'b0, ev);
        send(8'h20, 1'b0, ev); check("R10 running status cancelled", {25'd0, ev}, 32'd0);
        check_buf("R10 buffer untouched", 8'h90, 8'h3C, 8'h40);
        send(8'h80, 1'b0, ev);
        send(8'h10, 1'b0, ev);
        send(8'h20, 1'b0, ev); check("R10 new status resumes", {25'd0, ev}, 32'h01);
    endtask

    initial begin
        t_reset_state();
        t_note_on();
        t_running();
        t_vel_zero();
        t_one_byte();
        t_other_kinds();
        t_status_mid();
        t_error();
        t_realtime();
        t_syscom();
        t_orphan_data();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule